// File: doc/BRIEF.md
# Receive Flow-Control Character Screen

This block sits between a serial receiver's byte output and the write port of the receive FIFO. Each received byte arrives with a one-cycle valid strobe. In that same cycle the block decides whether the byte is stored. It also records two sticky events: a special-character hit and a stop-request hit. An interrupt request is formed from these events. A halt indication for the local transmitter is kept up to date.

Software selects one of two stop/go character pairs with a two-bit mode input. The mode can also turn pair matching off. The second stop character also serves as the special character. When the second pair is active, a received second stop character is consumed by flow control and is never stored. It still raises the special-character event. A byte can be accepted on every clock.

Top module: `rx_char_screen`

## Requirements
- R1: While reset is asserted and after it is released, `stat_spchar`, `stat_stop`, `irq` and `tx_halt` are 0, and `fifo_we` is 0 whenever `rx_valid` is 0.
- R2: With `spchar_en` = 0, a byte equal to `stop2_chr` never sets `stat_spchar`, and outside flow-control matching it is written to the FIFO.
- R3: With `spchar_en` = 1, a valid byte equal to `stop2_chr` bit for bit (bit 0 = LSB of the byte) sets `stat_spchar` on the next clock. When that byte is not a flow-control match, it is still written to the FIFO.
- R4: With `fc_mode` = 2'b10 (pair 1 active), a valid byte equal to `stop1_chr` is not written to the FIFO. It sets `stat_stop` and asserts `tx_halt` from the next clock. Special-character detection on `stop2_chr` works independently of this.
- R5: With `fc_mode` = 2'b01 (pair 2 active), a valid byte equal to `stop2_chr` is not written to the FIFO. It sets `stat_stop`, sets `stat_spchar` when `spchar_en` = 1, and asserts `tx_halt` from the next clock.
- R6: A valid byte equal to the go character of the active pair (`go1_chr` for 2'b10, `go2_chr` for 2'b01) is not written to the FIFO and clears `tx_halt` from the next clock.
- R7: With `fc_mode` = 2'b00 or 2'b11, no stop/go matching takes place: such bytes are written and leave `stat_stop` unchanged. `tx_halt` is 0 from the clock after one of these modes is applied.
- R8: Status bits stay set until a one-cycle `stat_clr` pulse, which clears them on the next clock. A new event in the same cycle as the clear wins, and the bit stays set.
- R9: `irq` is 1 exactly when `irq_en` = 1 and at least one status bit is set.
- R10: In the cycle `rx_valid` is 1, `fifo_we` equals 1 unless the byte is a flow-control match, and `fifo_wdata` equals `rx_data`. Bytes on consecutive cycles are each handled.
- R11: When the active pair's stop and go characters are equal, a matching byte counts as a stop: `tx_halt` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| rx_data | input | DW | Received byte |
| spchar_en | input | 1 | Special-character detection enable |
| fc_mode | input | 2 | Stop/go pair select: 10 pair 1, 01 pair 2, 00/11 none |
| go1_chr | input | DW | Pair 1 resume character |
| go2_chr | input | DW | Pair 2 resume character |
| stop1_chr | input | DW | Pair 1 halt character |
| stop2_chr | input | DW | Pair 2 halt character, also the special character |
| irq_en | input | 1 | Interrupt enable for the status events |
| stat_clr | input | 1 | One-cycle clear of the sticky status |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | DW | Receive FIFO write data |
| stat_spchar | output | 1 | Sticky special-character event |
| stat_stop | output | 1 | Sticky stop-character event |
| irq | output | 1 | Interrupt request |
| tx_halt | output | 1 | Halt request for the local transmitter |

## Verification
The hardest case to reach is a byte that matches in more than one way at once. Examples are `stop2_chr` arriving while pair 2 is active, with the special-character enable both on and off, and an active pair whose stop and go characters are equal. The stimulus steers into these cases on purpose. It also runs a long random phase that draws bytes mostly from the programmed characters, so that mode changes and status clears collide with matches. A behavioural model predicts every output on every cycle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [1:0] {
    FC_OFF    = 2'b00,
    FC_PAIR2  = 2'b01,
    FC_PAIR1  = 2'b10,
    FC_OFF_B  = 2'b11
  } fc_mode_e;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_SP   = 0;
  localparam int unsigned FLAG_STOP = 1;

  localparam int unsigned NUM_REFS  = 3;
  localparam int unsigned REF_GO    = 0;
  localparam int unsigned REF_STOP  = 1;
  localparam int unsigned REF_SPC   = 2;

  // Next state of the transmit-halt flag; stop has priority over go.
  function automatic logic halt_next(input logic active, input logic stop_hit,
                                     input logic go_hit, input logic cur);
    if (!active)       return 1'b0;
    else if (stop_hit) return 1'b1;
    else if (go_hit)   return 1'b0;
    else               return cur;
  endfunction

endpackage

// File: rtl/rcs_cmp.sv
module rcs_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          hit_o
);
  logic [DW-1:0] bit_eq;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/rcs_pair_sel.sv
module rcs_pair_sel
  import rcs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] go1_i,
  input  logic [DW-1:0] go2_i,
  input  logic [DW-1:0] stop1_i,
  input  logic [DW-1:0] stop2_i,
  output logic [DW-1:0] go_o,
  output logic [DW-1:0] stop_o,
  output logic          active_o
);
  always_comb begin
    go_o     = '0;
    stop_o   = '0;
    active_o = 1'b0;
    unique case (fc_mode_e'(mode_i))
      FC_PAIR1: begin
        go_o     = go1_i;
        stop_o   = stop1_i;
        active_o = 1'b1;
      end
      FC_PAIR2: begin
        go_o     = go2_i;
        stop_o   = stop2_i;
        active_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rcs_flags.sv
module rcs_flags #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic          clr_i,
  output logic [NF-1:0] q_o
);
  for (genvar f = 0; f < NF; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q_o[f] <= 1'b0;
      else if (set_i[f])  q_o[f] <= 1'b1;
      else if (clr_i)     q_o[f] <= 1'b0;
    end

    assert_set_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[f] |=> q_o[f]);
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[f]) |=> !q_o[f]);
    assert_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i[f]) |=> $stable(q_o[f]));
  end
endmodule

// File: rtl/rx_char_screen.sv
module rx_char_screen
  import rcs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          spchar_en,
  input  logic [1:0]    fc_mode,
  input  logic [DW-1:0] go1_chr,
  input  logic [DW-1:0] go2_chr,
  input  logic [DW-1:0] stop1_chr,
  input  logic [DW-1:0] stop2_chr,
  input  logic          irq_en,
  input  logic          stat_clr,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata,
  output logic          stat_spchar,
  output logic          stat_stop,
  output logic          irq,
  output logic          tx_halt
);
  // Active pair
  logic [DW-1:0] sel_go, sel_stop;
  logic          pair_active;

  rcs_pair_sel #(.DW(DW)) u_sel (
    .mode_i  (fc_mode),
    .go1_i   (go1_chr),
    .go2_i   (go2_chr),
    .stop1_i (stop1_chr),
    .stop2_i (stop2_chr),
    .go_o    (sel_go),
    .stop_o  (sel_stop),
    .active_o(pair_active)
  );

  // Comparators against each reference
  logic [DW-1:0]       ref_chr [NUM_REFS];
  logic [NUM_REFS-1:0] ref_hit;

  assign ref_chr[REF_GO]   = sel_go;
  assign ref_chr[REF_STOP] = sel_stop;
  assign ref_chr[REF_SPC]  = stop2_chr;

  for (genvar r = 0; r < NUM_REFS; r++) begin : g_cmp
    rcs_cmp #(.DW(DW)) u_cmp (
      .a_i  (rx_data),
      .b_i  (ref_chr[r]),
      .hit_o(ref_hit[r])
    );
  end

  // Named events
  logic stop_evt, go_evt, spc_evt, fc_consume;

  assign stop_evt   = rx_valid && pair_active && ref_hit[REF_STOP];
  assign go_evt     = rx_valid && pair_active && ref_hit[REF_GO] && !ref_hit[REF_STOP];
  assign spc_evt    = rx_valid && spchar_en && ref_hit[REF_SPC];
  assign fc_consume = stop_evt || go_evt;

  // FIFO write path
  assign fifo_we    = rx_valid && !fc_consume;
  assign fifo_wdata = rx_data;

  // Sticky status
  logic [NUM_FLAGS-1:0] flag_set, flag_q;

  assign flag_set[FLAG_SP]   = spc_evt;
  assign flag_set[FLAG_STOP] = stop_evt;

  rcs_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(flag_set),
    .clr_i(stat_clr),
    .q_o  (flag_q)
  );

  assign stat_spchar = flag_q[FLAG_SP];
  assign stat_stop   = flag_q[FLAG_STOP];
  assign irq         = irq_en && (|flag_q);

  // Transmit halt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_halt <= 1'b0;
    else        tx_halt <= halt_next(pair_active, stop_evt, go_evt, tx_halt);
  end

  // Assertions
  assert_consumed_not_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pair_active && (ref_hit[REF_STOP] || ref_hit[REF_GO])) |-> !fifo_we);
  assert_plain_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !pair_active) |-> (fifo_we && fifo_wdata == rx_data));
  assert_no_write_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !fifo_we);
  assert_halt_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> tx_halt);
  assert_halt_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt |=> !tx_halt);
  assert_halt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_active |=> !tx_halt);
  assert_spc_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spc_evt |=> stat_spchar);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_stop) && irq_en) |-> irq);
endmodule

// File: tb/rx_char_screen_test.sv
module rx_char_screen_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          v = 1'b0;
  logic [DW-1:0] d = '0;
  logic          spen = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] go1 = 8'h11, go2 = 8'h51, stop1 = 8'h13, stop2 = 8'h53;
  logic          ien = 1'b0;
  logic          clr = 1'b0;
  logic          we;
  logic [DW-1:0] wdata;
  logic          st_sp, st_stop, irq, halt;

  int checks = 0;
  int fails  = 0;
  bit m_sp = 0, m_stop = 0, m_halt = 0;

  always #2.5 clk = ~clk;

  rx_char_screen #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(v), .rx_data(d), .spchar_en(spen),
    .fc_mode(mode), .go1_chr(go1), .go2_chr(go2), .stop1_chr(stop1),
    .stop2_chr(stop2), .irq_en(ien), .stat_clr(clr), .fifo_we(we),
    .fifo_wdata(wdata), .stat_spchar(st_sp), .stat_stop(st_stop),
    .irq(irq), .tx_halt(halt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural prediction of one cycle (called at negedge with inputs set)
  task automatic step(input string req, input bit vv, input logic [7:0] dd, input bit cc);
    bit active, is_stop, is_go, is_sp;
    logic [7:0] g, s;
    v = vv; d = dd; clr = cc;
    #1;
    active = (mode == 2'b10) || (mode == 2'b01);
    g = (mode == 2'b10) ? go1 : go2;
    s = (mode == 2'b10) ? stop1 : stop2;
    is_stop = active && (dd == s);
    is_go   = active && (dd == g) && !is_stop;
    is_sp   = spen && (dd == stop2);
    chk(req, "fifo_we", int'(we), int'(vv && !(is_stop || is_go)));
    if (vv) chk(req, "fifo_wdata", int'(wdata), int'(dd));
    chk(req, "stat_spchar", int'(st_sp), int'(m_sp));
    chk(req, "stat_stop", int'(st_stop), int'(m_stop));
    chk(req, "irq", int'(irq), int'(ien && (m_sp || m_stop)));
    chk(req, "tx_halt", int'(halt), int'(m_halt));
    @(posedge clk);
    if (vv && is_sp) m_sp = 1; else if (cc) m_sp = 0;
    if (vv && is_stop) m_stop = 1; else if (cc) m_stop = 0;
    if (!active) m_halt = 0;
    else if (vv && is_stop) m_halt = 1;
    else if (vv && is_go) m_halt = 0;
    @(negedge clk);
    v = 0; clr = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "stat_spchar", int'(st_sp), 0);
    chk("R1", "stat_stop", int'(st_stop), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "tx_halt", int'(halt), 0);
    chk("R1", "fifo_we", int'(we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 8'h00, 0);

    // R2: detection off
    spen = 0; mode = 2'b00;
    step("R2", 1, stop2, 0);
    step("R2", 0, 8'h00, 0);

    // R10: back-to-back bytes
    for (int i = 0; i < 8; i++) step("R10", 1, 8'(8'hA0 + i), 0);

    // R3: detection on, written and flagged
    spen = 1;
    step("R3", 1, stop2, 0);
    step("R3", 0, 8'h00, 0);
    // R9: interrupt follows enable
    ien = 1; step("R9", 0, 8'h00, 0);
    ien = 0; step("R9", 0, 8'h00, 0);
    ien = 1;
    // R8: clear
    step("R8", 0, 8'h00, 1);
    step("R8", 0, 8'h00, 0);

    // R4: pair 1
    mode = 2'b10;
    step("R4", 1, stop1, 0);
    step("R4", 1, stop2, 0);
    step("R4", 0, 8'h00, 0);
    // R6: go of pair 1
    step("R6", 1, go1, 0);
    step("R6", 1, go2, 0);
    step("R6", 0, 8'h00, 1);

    // R5: pair 2
    mode = 2'b01;
    step("R5", 1, stop2, 0);
    step("R5", 0, 8'h00, 1);
    spen = 0;
    step("R5", 1, stop2, 0);
    step("R5", 1, stop1, 0);
    step("R6", 1, go2, 0);
    step("R6", 0, 8'h00, 1);
    spen = 1;

    // R7: no matching in 00 / 11, halt released on mode change
    mode = 2'b10; step("R7", 1, stop1, 0);
    mode = 2'b00; step("R7", 1, stop1, 1);
    step("R7", 1, go1, 0);
    mode = 2'b11; step("R7", 1, stop2, 0);
    step("R7", 1, go2, 1);
    step("R7", 0, 8'h00, 1);

    // R8: set wins over clear
    mode = 2'b01;
    step("R8", 1, stop2, 1);
    step("R8", 0, 8'h00, 0);
    step("R8", 0, 8'h00, 1);

    // R11: equal stop and go characters
    mode = 2'b10; go1 = 8'h22; stop1 = 8'h22;
    step("R11", 1, 8'h22, 0);
    step("R11", 1, 8'h22, 0);
    go1 = 8'h11; stop1 = 8'h13;
    step("R11", 0, 8'h00, 1);

    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] pick;
      int sel;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: pick = go1;
        1: pick = go2;
        2: pick = stop1;
        3: pick = stop2;
        default: pick = 8'($urandom);
      endcase
      if ($urandom_range(0, 15) == 0) mode = 2'($urandom);
      if ($urandom_range(0, 15) == 0) spen = 1'($urandom);
      if ($urandom_range(0, 15) == 0) ien = 1'($urandom);
      step("R10", 1'($urandom_range(0, 3) != 0), pick, $urandom_range(0, 7) == 0);
    end

    summary();
    $finish;
  end
endmodule